// File: doc/BRIEF.md
# Single DMA Channel with Double-Buffered Setup

This block is the control half of one DMA channel. Its source address, destination address and transfer count each live in a pair of registers: a master copy that software writes and a slave copy that drives the transfer in progress. Each pulse on the trigger input asks for one transfer unit. The channel answers with a one-cycle request that carries the current source and destination addresses, then advances both addresses by the unit size and counts down by one.

When the count runs out, the channel raises a sticky terminal-count flag and a one-cycle end-of-transfer interrupt, and it copies the master copies into the slave copies. What happens next depends on the multi-link bit. With the bit clear, the channel disables itself. With the bit set, it stays enabled, and the next trigger starts the freshly loaded setup without any software action. Software queues the next setup by writing the registers while a transfer runs. Before the channel is enabled and has seen its first trigger, writes go to both copies. After that, they go to the master copy only.

The bus master that carries out each request, and arbitration between channels, sit outside this block.

Top module: `dmach_dualbuf`

## Requirements
- R1: After reset, req_valid, tc_flag and eot_irq are 0, the channel is disabled with multi-link off, and all master and slave registers hold 0.
- R2: Writes use wr_sel 0 for source, 1 for destination, 2 for count (low CW bits of wr_data) and 3 for control. While the channel is disabled, or is enabled but has not yet seen a trigger, a source, destination or count write updates both the master and the slave copy.
- R3: A trigger while the channel is disabled produces no request and changes no state.
- R4: Once the channel is enabled and has seen a trigger, source, destination and count writes update only the master copy. The transfer in progress keeps using the old slave values.
- R5: A trigger on an enabled channel with a nonzero slave count produces one cycle of req_valid, with req_src and req_dst equal to the slave addresses. Afterwards both slave addresses grow by UNIT_BYTES and the slave count drops by one.
- R6: When a unit brings the slave count to zero, tc_flag becomes 1 and eot_irq is high for exactly that one cycle, together with the final request.
- R7: At terminal count, the slave copies load the master values, including a master write made in that same cycle. If no new master setup was written, the previous setup repeats.
- R8: With multi-link (control bit 1) clear, terminal count disables the channel. Later triggers are ignored until software writes control bit 0 to 1 again.
- R9: With multi-link set, the channel stays enabled after terminal count. The next trigger starts the reloaded setup even while tc_flag is still 1, and each terminal count raises eot_irq again.
- R10: A control write with bit 2 set clears tc_flag. If terminal count occurs in the same cycle, the flag stays set.
- R11: A trigger in the same cycle as an address or count write that reaches the slave copy uses the newly written value. A control write takes effect only from the next cycle.
- R12: A trigger while the slave count is 0 produces no request and no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 source, 1 destination, 2 count, 3 control |
| wr_data | input | AW | Write data; control bits are 0 enable, 1 multi-link, 2 clear terminal-count flag |
| trig | input | 1 | Request for one transfer unit |
| req_valid | output | 1 | One-cycle transfer request |
| req_src | output | AW | Source address of the request |
| req_dst | output | AW | Destination address of the request |
| tc_flag | output | 1 | Sticky terminal-count flag |
| eot_irq | output | 1 | One-cycle end-of-transfer interrupt |

## Verification
The hardest state to reach is a queued setup that differs from the running one. The channel has to be enabled and already triggered, with writes landing in the master copy only, and the only way to see those master values from the ports is the first request after the next reload. The stimulus therefore arms the channel, writes a different source address and count in the middle of the transfer, and checks that the remaining units still use the old addresses. It then drives the transfer to terminal count and checks that the first request afterwards carries the queued values, in both the self-disabling mode and the multi-link mode. Same-cycle collisions are driven on purpose: a write coinciding with a trigger, and a flag clear coinciding with terminal count.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } dmach_sel_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_ML_BIT  = 1;
    localparam int CTL_CLR_BIT = 2;

    localparam int STEP_UP   = 0;
    localparam int STEP_DOWN = 1;
endpackage

// File: rtl/dmach_bufreg.sv
module dmach_bufreg #(
    parameter int W        = 32,
    parameter int STEP_MODE = 0,
    parameter int STEP_AMT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_both,
    input  logic         wr_mst,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic         reload,
    output logic [W-1:0] slave_eff
);
    import dmach_pkg::*;

    localparam logic [W-1:0] STEP_VAL = W'(STEP_AMT);

    typedef struct packed {
        logic [W-1:0] mst;
        logic [W-1:0] slv;
    } pair_t;

    pair_t        r_d, r_q;
    logic [W-1:0] stepped;

    generate
        if (STEP_MODE == STEP_DOWN) begin : g_down
            assign stepped = slave_eff - W'(1);
        end else begin : g_up
            assign stepped = slave_eff + STEP_VAL;
        end
    endgenerate

    always_comb begin
        slave_eff = wr_both ? wdata : r_q.slv;
        r_d = r_q;
        if (wr_both || wr_mst) r_d.mst = wdata;
        if (wr_both)           r_d.slv = wdata;
        if (step)              r_d.slv = stepped;
        if (reload)            r_d.slv = r_d.mst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    a_r4_slave_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mst && !wr_both && !step && !reload) |=> $stable(r_q.slv));

    a_r7_reload_match: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (r_q.slv == r_q.mst));
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          ctl_ml,
    input  logic          ctl_clr,
    input  logic [CW-1:0] cnt_eff,
    input  logic [AW-1:0] src_eff,
    input  logic [AW-1:0] dst_eff,
    output logic          mst_only,
    output logic          fire,
    output logic          last,
    output logic          req_valid,
    output logic [AW-1:0] req_src,
    output logic [AW-1:0] req_dst,
    output logic          tc,
    output logic          irq
);
    typedef struct packed {
        logic          en;
        logic          ml;
        logic          armed;
        logic          tc;
        logic          req;
        logic          irq;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        mst_only = s_q.en && s_q.armed;
        fire     = s_q.en && trig && (cnt_eff != '0);
        last     = fire && (cnt_eff == CW'(1));

        s_d     = s_q;
        s_d.req = fire;
        s_d.irq = last;
        if (fire) begin
            s_d.src = src_eff;
            s_d.dst = dst_eff;
        end
        if (s_q.en && trig) s_d.armed = 1'b1;
        if (last && !s_q.ml) begin
            s_d.en    = 1'b0;
            s_d.armed = 1'b0;
        end
        if (ctl_wr) begin
            s_d.en = ctl_en;
            s_d.ml = ctl_ml;
            if (!ctl_en) s_d.armed = 1'b0;
            if (ctl_clr) s_d.tc = 1'b0;
        end
        if (last) s_d.tc = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_valid = s_q.req;
    assign req_src   = s_q.src;
    assign req_dst   = s_q.dst;
    assign tc        = s_q.tc;
    assign irq       = s_q.irq;

    a_r6_irq_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> (s_q.req && s_q.tc));

    a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |-> ($past(s_q.en) && $past(trig)));

    a_r12_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && cnt_eff == '0) |=> !s_q.req);

    a_r10_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tc && !(ctl_wr && ctl_clr)) |=> s_q.tc);

    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !s_q.ml && !ctl_wr) |=> !mst_only);
endmodule

// File: rtl/dmach_dualbuf.sv
module dmach_dualbuf #(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int UNIT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          trig,
    output logic          req_valid,
    output logic [AW-1:0] req_src,
    output logic [AW-1:0] req_dst,
    output logic          tc_flag,
    output logic          eot_irq
);
    import dmach_pkg::*;

    localparam int NADDR = 2;

    logic          mst_only, fire, last;
    logic          ctl_wr;
    logic [AW-1:0] addr_eff [NADDR];
    logic [CW-1:0] cnt_eff;
    logic          cnt_hit;

    assign ctl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign cnt_hit = wr_en && (wr_sel == SEL_CNT);

    generate
        for (genvar i = 0; i < NADDR; i++) begin : g_addr
            logic hit;
            assign hit = wr_en && (wr_sel == 2'(i));
            dmach_bufreg #(
                .W(AW), .STEP_MODE(STEP_UP), .STEP_AMT(UNIT_BYTES)
            ) u_addr (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_both  (hit && !mst_only),
                .wr_mst   (hit && mst_only),
                .wdata    (wr_data),
                .step     (fire),
                .reload   (last),
                .slave_eff(addr_eff[i])
            );
        end
    endgenerate

    dmach_bufreg #(
        .W(CW), .STEP_MODE(STEP_DOWN), .STEP_AMT(1)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_both  (cnt_hit && !mst_only),
        .wr_mst   (cnt_hit && mst_only),
        .wdata    (wr_data[CW-1:0]),
        .step     (fire),
        .reload   (last),
        .slave_eff(cnt_eff)
    );

    dmach_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .ctl_wr   (ctl_wr),
        .ctl_en   (wr_data[CTL_EN_BIT]),
        .ctl_ml   (wr_data[CTL_ML_BIT]),
        .ctl_clr  (wr_data[CTL_CLR_BIT]),
        .cnt_eff  (cnt_eff),
        .src_eff  (addr_eff[SEL_SRC]),
        .dst_eff  (addr_eff[SEL_DST]),
        .mst_only (mst_only),
        .fire     (fire),
        .last     (last),
        .req_valid(req_valid),
        .req_src  (req_src),
        .req_dst  (req_dst),
        .tc       (tc_flag),
        .irq      (eot_irq)
    );

    a_r5_req_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req_valid);

    a_r6_irq_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        eot_irq |-> $past(last));
endmodule

// File: tb/dmach_dualbuf_bench.sv
`timescale 1ns/1ps
module dmach_dualbuf_bench;
    localparam int U = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        trig = 0;
    logic        req_valid, tc_flag, eot_irq;
    logic [31:0] req_src, req_dst;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dmach_dualbuf u_dmach_dualbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .trig(trig), .req_valid(req_valid),
        .req_src(req_src), .req_dst(req_dst), .tc_flag(tc_flag),
        .eot_irq(eot_irq)
    );

    // behavioural reference model
    bit          m_en, m_ml, m_armed, m_tc, m_req, m_irq;
    logic [31:0] ms_src, ms_dst, mm_src, mm_dst, m_rs, m_rd;
    logic [15:0] ms_cnt, mm_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ml = 0; m_armed = 0; m_tc = 0; m_req = 0; m_irq = 0;
            ms_src = 0; ms_dst = 0; mm_src = 0; mm_dst = 0;
            ms_cnt = 0; mm_cnt = 0; m_rs = 0; m_rd = 0;
        end else begin
            bit en0, ml0, to_slave, hit_last;
            en0 = m_en; ml0 = m_ml; hit_last = 0;
            to_slave = !(m_en && m_armed);
            m_req = 0; m_irq = 0;
            if (wr_en && wr_sel == 0) begin mm_src = wr_data; if (to_slave) ms_src = wr_data; end
            if (wr_en && wr_sel == 1) begin mm_dst = wr_data; if (to_slave) ms_dst = wr_data; end
            if (wr_en && wr_sel == 2) begin mm_cnt = wr_data[15:0]; if (to_slave) ms_cnt = wr_data[15:0]; end
            if (en0 && trig && ms_cnt != 0) begin
                m_req = 1; m_rs = ms_src; m_rd = ms_dst;
                ms_src = ms_src + U; ms_dst = ms_dst + U; ms_cnt = ms_cnt - 1;
                if (ms_cnt == 0) begin
                    hit_last = 1; m_irq = 1;
                    ms_src = mm_src; ms_dst = mm_dst; ms_cnt = mm_cnt;
                end
            end
            if (en0 && trig) m_armed = 1;
            if (hit_last && !ml0) begin m_en = 0; m_armed = 0; end
            if (wr_en && wr_sel == 3) begin
                m_en = wr_data[0]; m_ml = wr_data[1];
                if (!wr_data[0]) m_armed = 0;
                if (wr_data[2]) m_tc = 0;
            end
            if (hit_last) m_tc = 1;
        end
    end

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({tag, " req_valid"}, 32'(req_valid), 32'(m_req));
            if (m_req) begin
                chk({tag, " req_src"}, req_src, m_rs);
                chk({tag, " req_dst"}, req_dst, m_rd);
            end
            chk({tag, " tc_flag"}, 32'(tc_flag), 32'(m_tc));
            chk({tag, " eot_irq"}, 32'(eot_irq), 32'(m_irq));
        end
    end

    task automatic drive(bit w, logic [1:0] s, logic [31:0] d, bit t);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; trig = t;
        @(negedge clk);
        wr_en = 0; trig = 0;
    endtask
    task automatic wr(logic [1:0] s, logic [31:0] d); drive(1, s, d, 0); endtask
    task automatic pulse(); drive(0, 0, 0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset req_valid", 32'(req_valid), 0);
        chk("R1 reset tc_flag", 32'(tc_flag), 0);
        chk("R1 reset eot_irq", 32'(eot_irq), 0);

        tag = "R3"; pulse();
        chk("R3 disabled trigger", 32'(req_valid), 0);

        tag = "R2";
        wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 3); wr(3, 1);
        tag = "R5"; pulse();
        chk("R2 slave src", req_src, 32'h1000);
        chk("R5 dst", req_dst, 32'h2000);
        tag = "R4"; wr(0, 32'h5000); pulse();
        chk("R4 master-only write", req_src, 32'h1004);
        tag = "R6"; pulse();
        chk("R6 irq", 32'(eot_irq), 1);
        chk("R6 last src", req_src, 32'h1008);
        @(negedge clk);
        chk("R6 irq one cycle", 32'(eot_irq), 0);
        tag = "R8"; pulse();
        chk("R8 stopped", 32'(req_valid), 0);
        wr(3, 1);
        tag = "R7"; pulse();
        chk("R7 reloaded src", req_src, 32'h5000);
        chk("R7 reloaded dst", req_dst, 32'h2000);
        tag = "R10"; wr(3, 32'h5);
        chk("R10 clear", 32'(tc_flag), 0);

        tag = "R9";
        wr(3, 0); wr(0, 32'h100); wr(1, 32'h200); wr(2, 2); wr(3, 3);
        pulse();
        wr(0, 32'h300); wr(2, 1);
        pulse();
        chk("R9 first irq", 32'(eot_irq), 1);
        pulse();
        chk("R9 auto restart", req_src, 32'h300);
        chk("R9 tc kept", 32'(tc_flag), 1);
        chk("R9 second irq", 32'(eot_irq), 1);
        pulse();
        chk("R7 repeat setup", req_src, 32'h300);

        tag = "R11";
        wr(3, 0); wr(3, 1);
        drive(1, 0, 32'h700, 1);
        chk("R11 same-cycle write", req_src, 32'h700);
        drive(1, 3, 32'h0, 1);
        chk("R11 ctrl next cycle", 32'(req_valid), 0);

        tag = "R10";
        wr(3, 5); wr(2, 1); wr(3, 1);
        drive(1, 3, 32'h5, 1);
        chk("R10 set wins", 32'(tc_flag), 1);

        tag = "R12";
        wr(3, 0); wr(2, 0); wr(3, 3); pulse();
        chk("R12 zero count", 32'(req_valid), 0);
        chk("R12 no irq", 32'(eot_irq), 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule